// File: doc/BRIEF.md
# Banked Display Byte Store with Subaddress Gating

This block keeps the pixel data of a dot-matrix LCD driver: four banks, each of forty bytes, addressed by a column pointer X (0 to 39) and a bank-row pointer Y (0 to 3). A serial slave front end, outside this block, decodes commands and hands over one byte strobe per transferred byte. Several such devices listen to the same bus and each keeps a copy of a 4-bit subaddress counter. Only the device whose fixed local subaddress equals that counter stores or returns the byte, so one long stream of bytes can be spread over a row of cascaded devices.

Every byte transfer advances the pointers, whether or not this device takes part. X counts up to the last column and then wraps to 0, which moves Y on by one. When Y wraps, the subaddress counter moves on, so the next device in the chain takes the stream over. Commands load the pointers, the subaddress counter and a start-bank pointer. A second read port, used by the display refresh logic, reads one column of a row group. The bank it reads is offset by the start bank, so the software can scroll the image or prepare one in the background.

Top module: `dispbank_ram`

## Requirements
- R1: After reset, X, Y, the subaddress counter and the start bank are all 0. Every stored byte is 0x00. rd_data, rd_ack and ref_data are 0.
- R2: When the subaddress counter equals the local subaddress (0 by default), a write strobe stores wr_data at bank Y, column X. A read strobe returns the byte at bank Y, column X on rd_data, with rd_ack high, on the cycle after the strobe.
- R3: A write strobe while the subaddress counter differs from the local subaddress leaves every stored byte unchanged.
- R4: A read strobe while the subaddress counter differs from the local subaddress returns 0xFF on rd_data with rd_ack low. rd_ack is low in every cycle that does not follow a read strobe.
- R5: Every write or read strobe, matched or not, advances X by one. When X is 39 it goes to 0 and Y advances by one. Without a strobe or command the pointers hold.
- R6: When a strobe finds X at 39 and Y at 3, Y goes to 0 and the subaddress counter advances by one, wrapping from 15 to 0.
- R7: cmd_ptr loads X from cmd_x and Y from cmd_y; a cmd_x above 39 loads X as 0. cmd_sub loads the subaddress counter from cmd_sub_val. cmd_bank loads the start bank from cmd_bank_val.
- R8: One cycle after any cycle, ref_data holds the byte at bank (start bank + ref_grp) mod 4, column ref_col. For a ref_col above 39 it holds 0x00. The contents are those from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ptr | input | 1 | Load X and Y pointers |
| cmd_x | input | 6 | Column value for cmd_ptr |
| cmd_y | input | 2 | Bank-row value for cmd_ptr |
| cmd_sub | input | 1 | Load subaddress counter |
| cmd_sub_val | input | 4 | Value for cmd_sub |
| cmd_bank | input | 1 | Load start-bank pointer |
| cmd_bank_val | input | 2 | Value for cmd_bank |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| rd_ack | output | 1 | High for one cycle after a matched read |
| ref_col | input | 6 | Refresh column |
| ref_grp | input | 2 | Refresh row group |
| ref_data | output | 8 | Refresh byte, one cycle latency |
| x_ptr | output | 6 | Current column pointer |
| y_ptr | output | 2 | Current bank-row pointer |
| sub_cnt | output | 4 | Current subaddress counter |
| start_bank | output | 2 | Current start-bank pointer |

## Verification
The assertions assume that the front end raises at most one of cmd_ptr, cmd_sub, wr_en and rd_en in any cycle, because the block gives no priority among them. cmd_bank and the refresh inputs may change in any cycle. The random stimulus picks exactly one operation per cycle from a weighted choice, so it stays within that rule. It keeps the subaddress counter at the local value most of the time and still crosses the X, Y and subaddress wrap points. Its refresh column runs past 39 so that the out-of-range case is covered.

// File: rtl/dispram_pkg.sv
package dispram_pkg;
    localparam int DEF_COLS  = 40;
    localparam int DEF_BANKS = 4;
    localparam int DEF_SUB_W = 4;

    typedef struct packed {
        logic [7:0] rd_data;
        logic       rd_ack;
        logic [7:0] ref_data;
    } port_regs_t;
endpackage

// File: rtl/ptr_unit.sv
module ptr_unit #(
    parameter int COLS  = dispram_pkg::DEF_COLS,
    parameter int BANKS = dispram_pkg::DEF_BANKS,
    parameter int SUB_W = dispram_pkg::DEF_SUB_W,
    localparam int XW   = $clog2(COLS),
    localparam int YW   = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             cmd_ptr,
    input  logic [XW-1:0]    cmd_x,
    input  logic [YW-1:0]    cmd_y,
    input  logic             cmd_sub,
    input  logic [SUB_W-1:0] cmd_sub_val,
    input  logic             cmd_bank,
    input  logic [YW-1:0]    cmd_bank_val,
    output logic [XW-1:0]    x,
    output logic [YW-1:0]    y,
    output logic [SUB_W-1:0] sub,
    output logic [YW-1:0]    bank
);
    localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
    localparam logic [YW-1:0] YLAST = YW'(BANKS - 1);

    typedef struct packed {
        logic [XW-1:0]    x;
        logic [YW-1:0]    y;
        logic [SUB_W-1:0] sub;
        logic [YW-1:0]    bank;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_ptr) begin
            st_d.x = (int'(cmd_x) < COLS) ? cmd_x : '0;
            st_d.y = cmd_y;
        end else if (xfer) begin
            if (st_q.x == XLAST) begin
                st_d.x = '0;
                if (st_q.y == YLAST) begin
                    st_d.y   = '0;
                    st_d.sub = st_q.sub + 1'b1;
                end else begin
                    st_d.y = st_q.y + 1'b1;
                end
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
        if (cmd_sub)  st_d.sub  = cmd_sub_val;
        if (cmd_bank) st_d.bank = cmd_bank_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x    = st_q.x;
    assign y    = st_q.y;
    assign sub  = st_q.sub;
    assign bank = st_q.bank;

    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(x) < COLS); // R5
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !cmd_ptr && x != XLAST) |=> (x == $past(x) + 1'b1) && (y == $past(y))); // R5
    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !cmd_ptr && x == XLAST && y != YLAST) |=> (x == '0) && (y == $past(y) + 1'b1)); // R5
    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !cmd_ptr && !cmd_sub && x == XLAST && y == YLAST) |=> (y == '0) && (sub == $past(sub) + 1'b1)); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !cmd_ptr && !cmd_sub) |=> $stable(x) && $stable(y) && $stable(sub)); // R5
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bank |=> bank == $past(cmd_bank_val)); // R7
endmodule

// File: rtl/byte_array.sv
module byte_array #(
    parameter int DEPTH = dispram_pkg::DEF_COLS * dispram_pkg::DEF_BANKS,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = (int'(raddr_a) < DEPTH) ? mem_q[raddr_a] : 8'h00;
    assign rdata_b = (int'(raddr_b) < DEPTH) ? mem_q[raddr_b] : 8'h00;

    AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(waddr) < DEPTH); // R2
endmodule

// File: rtl/bank_map.sv
module bank_map #(
    parameter int COLS  = dispram_pkg::DEF_COLS,
    parameter int BANKS = dispram_pkg::DEF_BANKS,
    localparam int XW   = $clog2(COLS),
    localparam int YW   = $clog2(BANKS),
    localparam int AW   = $clog2(COLS * BANKS)
) (
    input  logic [YW-1:0] base,
    input  logic [YW-1:0] offset,
    input  logic [XW-1:0] col,
    output logic [AW-1:0] addr,
    output logic          valid
);
    int row_idx;

    always_comb begin
        row_idx = (int'(base) + int'(offset)) % BANKS;
        valid   = int'(col) < COLS;
        addr    = valid ? AW'(row_idx * COLS + int'(col)) : '0;
    end
endmodule

// File: rtl/dispbank_ram.sv
module dispbank_ram #(
    parameter int COLS      = dispram_pkg::DEF_COLS,
    parameter int BANKS     = dispram_pkg::DEF_BANKS,
    parameter int SUB_W     = dispram_pkg::DEF_SUB_W,
    parameter int LOCAL_SUB = 0,
    localparam int XW       = $clog2(COLS),
    localparam int YW       = $clog2(BANKS),
    localparam int DEPTH    = COLS * BANKS,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ptr,
    input  logic [XW-1:0]    cmd_x,
    input  logic [YW-1:0]    cmd_y,
    input  logic             cmd_sub,
    input  logic [SUB_W-1:0] cmd_sub_val,
    input  logic             cmd_bank,
    input  logic [YW-1:0]    cmd_bank_val,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_ack,
    input  logic [XW-1:0]    ref_col,
    input  logic [YW-1:0]    ref_grp,
    output logic [7:0]       ref_data,
    output logic [XW-1:0]    x_ptr,
    output logic [YW-1:0]    y_ptr,
    output logic [SUB_W-1:0] sub_cnt,
    output logic [YW-1:0]    start_bank
);
    import dispram_pkg::*;

    localparam logic [SUB_W-1:0] LOCAL_ID = SUB_W'(LOCAL_SUB);

    logic          match;
    logic          xfer;
    logic [AW-1:0] host_addr;
    logic          host_valid;
    logic [AW-1:0] ref_addr;
    logic          ref_valid;
    logic [7:0]    host_byte;
    logic [7:0]    ref_byte;

    port_regs_t pr_d, pr_q;

    assign xfer  = wr_en | rd_en;
    assign match = (sub_cnt == LOCAL_ID);

    ptr_unit #(.COLS(COLS), .BANKS(BANKS), .SUB_W(SUB_W)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer         (xfer),
        .cmd_ptr      (cmd_ptr),
        .cmd_x        (cmd_x),
        .cmd_y        (cmd_y),
        .cmd_sub      (cmd_sub),
        .cmd_sub_val  (cmd_sub_val),
        .cmd_bank     (cmd_bank),
        .cmd_bank_val (cmd_bank_val),
        .x            (x_ptr),
        .y            (y_ptr),
        .sub          (sub_cnt),
        .bank         (start_bank)
    );

    bank_map #(.COLS(COLS), .BANKS(BANKS)) u_host_map (
        .base   (y_ptr),
        .offset ('0),
        .col    (x_ptr),
        .addr   (host_addr),
        .valid  (host_valid)
    );

    bank_map #(.COLS(COLS), .BANKS(BANKS)) u_ref_map (
        .base   (start_bank),
        .offset (ref_grp),
        .col    (ref_col),
        .addr   (ref_addr),
        .valid  (ref_valid)
    );

    byte_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en & match & host_valid),
        .waddr   (host_addr),
        .wdata   (wr_data),
        .raddr_a (host_addr),
        .rdata_a (host_byte),
        .raddr_b (ref_addr),
        .rdata_b (ref_byte)
    );

    always_comb begin
        pr_d          = pr_q;
        pr_d.rd_ack   = 1'b0;
        if (rd_en) begin
            pr_d.rd_data = match ? host_byte : 8'hFF;
            pr_d.rd_ack  = match;
        end
        pr_d.ref_data = ref_valid ? ref_byte : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign rd_data  = pr_q.rd_data;
    assign rd_ack   = pr_q.rd_ack;
    assign ref_data = pr_q.ref_data;

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ptr, cmd_sub, wr_en, rd_en})); // R7
    AST_MISS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !match) |=> (rd_data == 8'hFF) && !rd_ack); // R4
    AST_HIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && match) |=> rd_ack); // R2
    AST_ACK_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_ack); // R4
    AST_REF_OOR: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ref_col) >= COLS) |=> ref_data == 8'h00); // R8
endmodule

// File: tb/dispbank_ram_test.sv
module dispbank_ram_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_ptr = 0, cmd_sub = 0, cmd_bank = 0, wr_en = 0, rd_en = 0;
    logic [5:0] cmd_x = 0, ref_col = 0;
    logic [1:0] cmd_y = 0, cmd_bank_val = 0, ref_grp = 0;
    logic [3:0] cmd_sub_val = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data, ref_data;
    logic       rd_ack;
    logic [5:0] x_ptr;
    logic [1:0] y_ptr, start_bank;
    logic [3:0] sub_cnt;

    int checks = 0;
    int errors = 0;

    byte unsigned mem_m [160];
    int mx, my, msub, mbank;
    int last_rd;

    always #5 clk = ~clk;

    dispbank_ram uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_ptr(cmd_ptr), .cmd_x(cmd_x), .cmd_y(cmd_y),
        .cmd_sub(cmd_sub), .cmd_sub_val(cmd_sub_val),
        .cmd_bank(cmd_bank), .cmd_bank_val(cmd_bank_val),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_ack(rd_ack),
        .ref_col(ref_col), .ref_grp(ref_grp), .ref_data(ref_data),
        .x_ptr(x_ptr), .y_ptr(y_ptr), .sub_cnt(sub_cnt), .start_bank(start_bank)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_expect(int col, int grp);
        if (col > 39) return 0;
        return mem_m[((mbank + grp) % 4) * 40 + col];
    endfunction

    // kind: 0 idle, 1 write, 2 read, 3 load ptr, 4 load sub
    task automatic cycle(int kind, int a, int b, int bnk_ld, int bnk_v, int rc, int rg);
        int exp_ref, exp_rd, exp_ack;
        bit hit;
        @(negedge clk);
        wr_en = (kind == 1); rd_en = (kind == 2);
        cmd_ptr = (kind == 3); cmd_sub = (kind == 4);
        wr_data = 8'(a); cmd_x = 6'(a); cmd_y = 2'(b); cmd_sub_val = 4'(a);
        cmd_bank = bnk_ld[0]; cmd_bank_val = 2'(bnk_v);
        ref_col = 6'(rc); ref_grp = 2'(rg);
        exp_ref = ref_expect(rc, rg);
        hit = (msub == 0);
        exp_ack = 0;
        if (kind == 2) begin
            last_rd = hit ? int'(mem_m[my * 40 + mx]) : 255;
            exp_ack = hit;
        end
        exp_rd = last_rd;
        if (kind == 1 && hit) mem_m[my * 40 + mx] = 8'(a);
        if (kind == 1 || kind == 2) begin
            if (mx == 39) begin
                mx = 0;
                if (my == 3) begin my = 0; msub = (msub + 1) % 16; end
                else my++;
            end else mx++;
        end
        if (kind == 3) begin mx = (a > 39) ? 0 : a; my = b; end
        if (kind == 4) msub = a;
        if (bnk_ld != 0) mbank = bnk_v;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; cmd_ptr = 0; cmd_sub = 0; cmd_bank = 0;
        check("R5", "x_ptr", x_ptr, mx);
        check("R5", "y_ptr", y_ptr, my);
        check("R6", "sub_cnt", sub_cnt, msub);
        check("R7", "start_bank", start_bank, mbank);
        check("R8", "ref_data", ref_data, exp_ref);
        if (kind == 2) begin
            if (hit) begin
                check("R2", "rd_data", rd_data, exp_rd);
                check("R2", "rd_ack", rd_ack, exp_ack);
            end else begin
                check("R4", "rd_data", rd_data, exp_rd);
                check("R4", "rd_ack", rd_ack, exp_ack);
            end
        end else begin
            check("R4", "rd_ack idle", rd_ack, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 160; i++) mem_m[i] = 0;
        mx = 0; my = 0; msub = 0; mbank = 0; last_rd = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "x_ptr", x_ptr, 0);
        check("R1", "y_ptr", y_ptr, 0);
        check("R1", "sub_cnt", sub_cnt, 0);
        check("R1", "start_bank", start_bank, 0);
        check("R1", "rd_data", rd_data, 0);
        check("R1", "rd_ack", rd_ack, 0);
        check("R1", "ref_data", ref_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 contents cleared: refresh bank 3 column 39
        cycle(0, 0, 0, 0, 0, 39, 3);

        // R2 write at column 39 then wrap (R5)
        cycle(3, 39, 2, 0, 0, 0, 0);
        cycle(1, 8'hA5, 0, 0, 0, 39, 2);
        cycle(0, 0, 0, 0, 0, 39, 2);
        cycle(3, 39, 2, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0, 0, 0);

        // R6 subaddress step on Y wrap
        cycle(3, 39, 3, 0, 0, 0, 0);
        cycle(1, 8'h3C, 0, 0, 0, 0, 0);
        check("R6", "sub after wrap", sub_cnt, 1);

        // R3 unmatched write leaves memory; R4 unmatched read
        cycle(3, 5, 1, 0, 0, 0, 0);
        cycle(1, 8'h77, 0, 0, 0, 0, 0);
        cycle(3, 5, 1, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0, 0, 0);
        cycle(4, 0, 0, 0, 0, 5, 1);
        check("R3", "unmatched write ignored", ref_data, 0);
        cycle(3, 5, 1, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0, 0, 0);
        check("R3", "read after unmatched write", rd_data, 0);

        // R6 wrap 15 -> 0
        cycle(4, 15, 0, 0, 0, 0, 0);
        cycle(3, 39, 3, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0, 0, 0);
        check("R6", "sub 15 wraps", sub_cnt, 0);

        // R7 out of range X load, R8 bank rotation and out of range column
        cycle(3, 50, 1, 1, 3, 45, 0);
        check("R7", "x clamp", x_ptr, 0);
        cycle(1, 8'h5A, 0, 0, 0, 0, 2);
        cycle(0, 0, 0, 0, 0, 0, 2);
        check("R8", "rotated bank", ref_data, 8'h5A);

        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            int kind = (r < 35) ? 1 : (r < 65) ? 2 : (r < 75) ? 3 : (r < 82) ? 4 : 0;
            int a = (kind == 4) ? (($urandom_range(0, 9) < 7) ? 0 : $urandom_range(0, 15))
                  : (kind == 3) ? $urandom_range(0, 63) : $urandom_range(0, 255);
            int bl = ($urandom_range(0, 9) == 0) ? 1 : 0;
            cycle(kind, a, $urandom_range(0, 3), bl, $urandom_range(0, 3),
                  $urandom_range(0, 47), $urandom_range(0, 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule